// File: doc/BRIEF.md
# Asynchronous Serial Port with Oversampled Receiver

This block sends and receives asynchronous serial frames for a control processor. A free-running prescaler turns the system clock into an oversampling tick. Each bit lasts a fixed number of ticks: 16 in normal mode and 8 in double-speed mode. The transmitter takes a word from a one-entry holding register and sends it on the serial line. The line carries a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits.

The receiver synchronises the incoming line and waits for a falling edge. It then votes on three samples near the middle of each bit. A start bit that the vote does not confirm sends the receiver back to idle. The result of a completed frame is held in a data register, together with ready, framing, parity and overrun flags. One read acknowledge clears the ready flag and all three error flags.

The processor writes the block through a small register port:
- address 0 is the transmit data,
- address 1 is the control word,
- address 2 is the prescaler reload.

Top module: `serial_async_port`

## Requirements
- R1: After reset, tx_empty is 1, and rx_ready, frame_err, parity_err and overrun_err are 0. The prescaler reload resets to 0xFF, so one normal-mode bit lasts 16*256 clock cycles.
- R2: A bit lasts OVS*(reload+1) clock cycles. OVS is 16 when control bit 7 (double speed) is 0 and 8 when it is 1. The reload is written at address 2.
- R3: While control bit 0 (transmit enable) is 0, txd follows gpio_out. While it is 1, txd carries the serial output, which stays high while nothing is being sent.
- R4: A transmitted frame is one low start bit, then the data LSB first, then the optional parity bit, then one high stop bit. It has two stop bits when control bit 8 is 1.
- R5: The size field, control bits 6:4, selects the number of data bits: 000=5, 001=6, 010=7, 011=8, 111=9. The codes 100, 101 and 110 behave as 8 bits.
- R6: Control bit 3 enables parity and control bit 2 selects odd (1) or even (0) parity. The parity bit sits after the data MSB and before the first stop bit.
- R7: A write to address 0 clears tx_empty. tx_empty returns to 1 when the transmitter takes the word. A word written while a frame is in flight is sent with no idle gap after that frame.
- R8: With control bit 1 (receive enable) set, a falling edge on rxd starts a frame. The start is accepted only if at least two of the samples at ticks 8, 9 and 10 (ticks 4, 5 and 6 in double speed) are low. Otherwise the receiver returns to idle.
- R9: Each data, parity and stop bit is decided by a majority of three samples at the same tick indices. A completed frame puts the data, right-aligned, on rx_data and sets rx_ready. A pulse on rd_ack clears rx_ready and all error flags.
- R10: parity_err is set with a stored frame whose received parity bit does not match the selected parity of its data bits.
- R11: frame_err is set with a stored frame whose stop bit is sampled low.
- R12: A frame that completes while rx_ready is still 1 sets overrun_err and leaves rx_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 control, 2 reload |
| wr_data | input | 9 | Register write value |
| rd_ack | input | 1 | Received word consumed; clears ready and error flags |
| rxd | input | 1 | Serial receive line |
| gpio_out | input | 1 | Port data driven on txd while the transmitter is disabled |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 9 | Last received word, right-aligned |
| rx_ready | output | 1 | Unread received word present |
| tx_empty | output | 1 | Transmit holding register can accept a word |
| frame_err | output | 1 | Stop bit of the stored frame was low |
| parity_err | output | 1 | Parity mismatch in the stored frame |
| overrun_err | output | 1 | A frame was lost because rx_ready was still set |

## Verification
Two situations are hard to reach from the ports.

The first is a falling edge on rxd that is not a start bit. The bench drives rxd low for fewer clocks than it takes to reach the first voting tick and then holds it high. It checks that no word appears, and that a proper frame sent right after it is still received intact, which shows the receiver went back to idle.

The second is back-to-back transmission. The bench refills the holding register while the first frame is still in flight, by watching tx_empty in a parallel thread. It then measures the distance between the two start edges to prove that no idle gap was inserted.

// File: rtl/sap_pkg.sv
package sap_pkg;

   // control word as written at address 1 (bit 8 down to bit 0)
   typedef struct packed {
      logic       two_stop;
      logic       dbl;
      logic [2:0] size;
      logic       par_en;
      logic       par_odd;
      logic       rx_en;
      logic       tx_en;
   } ctrl_t;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4
   } rx_state_t;

   localparam int WORD_W = 9;

   function automatic logic [3:0] size_to_bits(input logic [2:0] code);
      logic [3:0] n;
      case (code)
         3'b000:  n = 4'd5;
         3'b001:  n = 4'd6;
         3'b010:  n = 4'd7;
         3'b111:  n = 4'd9;
         default: n = 4'd8;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/sap_baud.sv
module sap_baud #(
   parameter int BAUD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BAUD_W-1:0] reload,
   output logic              tick
);
   logic [BAUD_W-1:0] cnt_q;

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= reload;
      else           cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/sap_tx.sv
module sap_tx
   import sap_pkg::*;
#(
   parameter int OVS_NORM = 16,
   parameter int OVS_DBL  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  ctrl_t             cfg,
   input  logic              buf_full,
   input  logic [WORD_W-1:0] buf_data,
   output logic              take,
   output logic              busy,
   output logic              line
);
   localparam int CW = $clog2(OVS_NORM);
   localparam int FW = 1 + WORD_W + 1 + 2;

   logic [FW-1:0]     sh_q, frame;
   logic [3:0]        left_q, nbits, total;
   logic [CW-1:0]     cnt_q, osr_last;
   logic [WORD_W-1:0] mask;
   logic              pbit, bit_end, last_end;

   assign nbits    = size_to_bits(cfg.size);
   assign mask     = {WORD_W{1'b1}} >> (4'd9 - nbits);
   assign pbit     = (^(buf_data & mask)) ^ cfg.par_odd;
   assign total    = 4'd1 + nbits + {3'b000, cfg.par_en} + (cfg.two_stop ? 4'd2 : 4'd1);
   assign osr_last = cfg.dbl ? CW'(OVS_DBL - 1) : CW'(OVS_NORM - 1);
   assign bit_end  = busy && tick && (cnt_q == osr_last);
   assign last_end = bit_end && (left_q == 4'd1);
   assign take     = tick && cfg.tx_en && buf_full && (!busy || last_end);
   assign line     = busy ? sh_q[0] : 1'b1;

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < WORD_W; i++) begin
         if (i < int'(nbits)) frame[1+i] = buf_data[i];
      end
      if (cfg.par_en) frame[1+int'(nbits)] = pbit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
         cnt_q  <= '0;
         busy   <= 1'b0;
      end else if (take) begin
         sh_q   <= frame;
         left_q <= total;
         cnt_q  <= '0;
         busy   <= 1'b1;
      end else if (busy && tick) begin
         if (bit_end) begin
            cnt_q  <= '0;
            sh_q   <= {1'b1, sh_q[FW-1:1]};
            left_q <= left_q - 4'd1;
            if (left_q == 4'd1) busy <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sap_rx.sv
module sap_rx
   import sap_pkg::*;
#(
   parameter int OVS_NORM = 16,
   parameter int OVS_DBL  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  ctrl_t             cfg,
   input  logic              rxd_s,
   output logic              done,
   output logic [WORD_W-1:0] done_data,
   output logic              done_fe,
   output logic              done_pe
);
   localparam int KW = $clog2(OVS_NORM) + 1;

   rx_state_t         state_q;
   logic [KW-1:0]     cnt_q, k, lo, hi, osr;
   logic [1:0]        ones_q, ones_nxt;
   logic [3:0]        bitn_q, nbits;
   logic [WORD_W-1:0] sh_q, aligned;
   logic              prev_q, par_q, in_win, maj, par_calc;

   assign nbits    = size_to_bits(cfg.size);
   assign k        = cnt_q + KW'(1);
   assign osr      = cfg.dbl ? KW'(OVS_DBL) : KW'(OVS_NORM);
   assign lo       = cfg.dbl ? KW'(OVS_DBL / 2) : KW'(OVS_NORM / 2);
   assign hi       = lo + KW'(2);
   assign in_win   = (k >= lo) && (k <= hi);
   assign ones_nxt = ones_q + {1'b0, in_win & rxd_s};
   assign maj      = ones_nxt[1];
   assign aligned  = sh_q >> (4'd9 - nbits);
   assign par_calc = (^aligned) ^ cfg.par_odd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= rxd_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         cnt_q     <= '0;
         ones_q    <= '0;
         bitn_q    <= '0;
         sh_q      <= '0;
         par_q     <= 1'b0;
         done      <= 1'b0;
         done_data <= '0;
         done_fe   <= 1'b0;
         done_pe   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!cfg.rx_en) begin
            state_q <= RX_IDLE;
         end else if (state_q == RX_IDLE) begin
            if (prev_q && !rxd_s) begin
               state_q <= RX_START;
               cnt_q   <= '0;
               ones_q  <= '0;
               bitn_q  <= '0;
            end
         end else if (tick) begin
            cnt_q  <= k;
            ones_q <= ones_nxt;
            if (k == hi) begin
               case (state_q)
                  RX_START: if (maj) state_q <= RX_IDLE;
                  RX_DATA: begin
                     sh_q   <= {maj, sh_q[WORD_W-1:1]};
                     bitn_q <= bitn_q + 4'd1;
                  end
                  RX_PAR:   par_q <= maj;
                  RX_STOP: begin
                     done      <= 1'b1;
                     done_data <= aligned;
                     done_fe   <= !maj;
                     done_pe   <= cfg.par_en && (par_q != par_calc);
                     state_q   <= RX_IDLE;
                  end
                  default: ;
               endcase
            end
            if (k == osr) begin
               cnt_q  <= '0;
               ones_q <= '0;
               case (state_q)
                  RX_START: state_q <= RX_DATA;
                  RX_DATA:  if (bitn_q == nbits) state_q <= cfg.par_en ? RX_PAR : RX_STOP;
                  RX_PAR:   state_q <= RX_STOP;
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/serial_async_port.sv
module serial_async_port
   import sap_pkg::*;
#(
   parameter int BAUD_W   = 8,
   parameter int OVS_NORM = 16,
   parameter int OVS_DBL  = 8,
   parameter int SYNC_LEN = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [8:0]  wr_data,
   input  logic        rd_ack,
   input  logic        rxd,
   input  logic        gpio_out,
   output logic        txd,
   output logic [8:0]  rx_data,
   output logic        rx_ready,
   output logic        tx_empty,
   output logic        frame_err,
   output logic        parity_err,
   output logic        overrun_err
);
   generate
      if (BAUD_W < 1 || BAUD_W > WORD_W) begin : g_bad_baud
         $error("BAUD_W must lie in 1..9");
      end
      if (OVS_DBL < 8 || OVS_DBL >= OVS_NORM) begin : g_bad_ovs
         $error("OVS_DBL must be at least 8 and below OVS_NORM");
      end
      if (SYNC_LEN < 2) begin : g_bad_sync
         $error("SYNC_LEN must be at least 2");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [BAUD_W-1:0] baud_q;
   logic [WORD_W-1:0] txbuf_q, rx_word;
   logic [SYNC_LEN-1:0] rsync_q;
   logic              buf_full_q, baud_tick, tx_take, tx_busy, tx_line;
   logic              rx_done, rx_fe, rx_pe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsync_q <= '1;
      else        rsync_q <= {rsync_q[SYNC_LEN-2:0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         baud_q     <= '1;
         txbuf_q    <= '0;
         buf_full_q <= 1'b0;
      end else begin
         if (tx_take) buf_full_q <= 1'b0;
         if (wr_en) begin
            case (wr_addr)
               2'd0: begin
                  txbuf_q    <= wr_data;
                  buf_full_q <= 1'b1;
               end
               2'd1:    ctrl_q <= ctrl_t'(wr_data);
               2'd2:    baud_q <= wr_data[BAUD_W-1:0];
               default: ;
            endcase
         end
      end
   end

   sap_baud #(.BAUD_W(BAUD_W)) baud_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (baud_q),
      .tick   (baud_tick)
   );

   sap_tx #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL)) tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .cfg      (ctrl_q),
      .buf_full (buf_full_q),
      .buf_data (txbuf_q),
      .take     (tx_take),
      .busy     (tx_busy),
      .line     (tx_line)
   );

   sap_rx #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .cfg       (ctrl_q),
      .rxd_s     (rsync_q[SYNC_LEN-1]),
      .done      (rx_done),
      .done_data (rx_word),
      .done_fe   (rx_fe),
      .done_pe   (rx_pe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_ready    <= 1'b0;
         frame_err   <= 1'b0;
         parity_err  <= 1'b0;
         overrun_err <= 1'b0;
      end else begin
         if (rd_ack) begin
            rx_ready    <= 1'b0;
            frame_err   <= 1'b0;
            parity_err  <= 1'b0;
            overrun_err <= 1'b0;
         end
         if (rx_done) begin
            if (rx_ready && !rd_ack) begin
               overrun_err <= 1'b1;
            end else begin
               rx_data    <= rx_word;
               rx_ready   <= 1'b1;
               frame_err  <= rx_fe;
               parity_err <= rx_pe;
            end
         end
      end
   end

   assign tx_empty = !buf_full_q;
   assign txd      = ctrl_q.tx_en ? tx_line : gpio_out;
endmodule

// File: rtl/serial_async_port_chk.sv
module serial_async_port_chk #(
   parameter int BAUD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic              tx_empty,
   input logic              rx_ready,
   input logic              overrun_err,
   input logic              frame_err,
   input logic [8:0]        rx_data,
   input logic              tick,
   input logic [BAUD_W-1:0] baud,
   input logic              tx_en,
   input logic              tx_busy,
   input logic              txd
);
   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && baud != '0) |=> !tick);

   // R7
   wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> !tx_empty);

   // R3
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !tx_busy) |-> txd);

   // R12
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_err) |-> (rx_ready && $stable(rx_data)));

   // R11
   fe_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> rx_ready);
endmodule

bind serial_async_port serial_async_port_chk #(.BAUD_W(BAUD_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .tx_empty    (tx_empty),
   .rx_ready    (rx_ready),
   .overrun_err (overrun_err),
   .frame_err   (frame_err),
   .rx_data     (rx_data),
   .tick        (baud_tick),
   .baud        (baud_q),
   .tx_en       (ctrl_q.tx_en),
   .tx_busy     (tx_busy),
   .txd         (txd)
);

// File: tb/serial_async_port_tb_top.sv
module serial_async_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [8:0] wr_data = 9'd0;
   logic       rd_ack = 1'b0;
   logic       rxd = 1'b1;
   logic       gpio_out = 1'b1;
   logic       txd, rx_ready, tx_empty, frame_err, parity_err, overrun_err;
   logic [8:0] rx_data;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   serial_async_port dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_ack(rd_ack), .rxd(rxd), .gpio_out(gpio_out), .txd(txd), .rx_data(rx_data),
      .rx_ready(rx_ready), .tx_empty(tx_empty), .frame_err(frame_err),
      .parity_err(parity_err), .overrun_err(overrun_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [8:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
   endtask

   task automatic cfg(input bit two, input bit dbl, input logic [2:0] sz,
                      input bit pe, input bit odd, input bit rxe, input bit txe);
      wr(2'd1, {two, dbl, sz, pe, odd, rxe, txe});
   endtask

   function automatic int mkframe(input logic [8:0] d, input int n, input bit pe,
                                  input bit odd, input int stops, output logic [15:0] f);
      int idx;
      logic p;
      f = '1;
      f[0] = 1'b0;
      p = odd;
      for (int i = 0; i < n; i++) begin
         f[1+i] = d[i];
         p = p ^ d[i];
      end
      idx = 1 + n;
      if (pe) begin
         f[idx] = p;
         idx++;
      end
      return idx + stops;
   endfunction

   task automatic rx_send(input logic [15:0] f, input int len, input int bitclk);
      for (int i = 0; i < len; i++) begin
         rxd = f[i];
         repeat (bitclk) @(negedge clk);
      end
      rxd = 1'b1;
   endtask

   task automatic tx_cap(input int len, input int bitclk, output logic [15:0] got,
                         output time fall_t);
      int t = 0;
      got = '1;
      while (txd !== 1'b0 && t < 60000) begin
         @(negedge clk);
         t++;
      end
      fall_t = $time;
      repeat (bitclk / 2) @(negedge clk);
      for (int i = 0; i < len; i++) begin
         got[i] = txd;
         if (i < len - 1) repeat (bitclk) @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
      chk(rx_ready === 1'b0, "R1 rx_ready", rx_ready, 0);
      chk({frame_err, parity_err, overrun_err} === 3'b000, "R1 error flags",
          {frame_err, parity_err, overrun_err}, 0);
   endtask

   task automatic t_gpio();
      gpio_out = 1'b0;
      @(negedge clk);
      chk(txd === 1'b0, "R3 txd follows gpio low", txd, 0);
      gpio_out = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1, "R3 txd follows gpio high", txd, 1);
   endtask

   task automatic t_default_rate();
      int lows = 0;
      int t = 0;
      cfg(0, 0, 3'b011, 0, 0, 0, 1);
      @(negedge clk);
      chk(txd === 1'b1, "R3 idle line high", txd, 1);
      wr(2'd0, 9'h001);
      while (txd !== 1'b0 && t < 10000) begin @(negedge clk); t++; end
      while (txd === 1'b0 && lows < 10000) begin @(negedge clk); lows++; end
      // R1 reset reload 0xFF -> 4096 clocks per normal bit
      chk(lows == 4096, "R1 default bit time", lows, 4096);
      repeat (10 * 4096) @(negedge clk);
   endtask

   task automatic t_tx_8n1();
      logic [15:0] exp, got;
      time ft;
      int len;
      wr(2'd2, 9'd3);
      cfg(0, 0, 3'b011, 0, 0, 0, 1);
      len = mkframe(9'h0A5, 8, 0, 0, 1, exp);
      wr(2'd0, 9'h0A5);
      tx_cap(len, 64, got, ft);
      chk(got[9:0] === exp[9:0], "R4 8N1 frame 0xA5", got[9:0], exp[9:0]);
      repeat (64) @(negedge clk);
   endtask

   task automatic t_tx_back_to_back();
      logic [15:0] ea, eb, ga, gb;
      time fa, fb;
      int len;
      cfg(1, 0, 3'b111, 1, 0, 0, 1);
      len = mkframe(9'h1A5, 9, 1, 0, 2, ea);
      void'(mkframe(9'h0F0, 9, 1, 0, 2, eb));
      wr(2'd0, 9'h1A5);
      chk(tx_empty === 1'b0, "R7 write clears tx_empty", tx_empty, 0);
      fork
         begin
            tx_cap(len, 64, ga, fa);
            tx_cap(len, 64, gb, fb);
         end
         begin
            wait (tx_empty === 1'b1);
            wr(2'd0, 9'h0F0);
         end
      join
      chk(ga[12:0] === ea[12:0], "R6 9-bit even parity frame A", ga[12:0], ea[12:0]);
      chk(gb[12:0] === eb[12:0], "R5 9-bit frame B", gb[12:0], eb[12:0]);
      // R4 two stop bits, R7 no gap: 13 bits of 64 clocks of 4 ns
      chk((fb - fa) == 13 * 64 * 4, "R7 back-to-back spacing", int'(fb - fa), 13 * 64 * 4);
      repeat (64) @(negedge clk);
   endtask

   task automatic t_tx_dbl_odd();
      logic [15:0] exp, got;
      time ft;
      int len;
      cfg(0, 1, 3'b000, 1, 1, 0, 1);
      len = mkframe(9'h016, 5, 1, 1, 1, exp);
      wr(2'd0, 9'h016);
      tx_cap(len, 32, got, ft);
      chk(got[7:0] === exp[7:0], "R2 R6 double-speed 5-bit odd parity", got[7:0], exp[7:0]);
      repeat (32) @(negedge clk);
   endtask

   task automatic t_tx_reserved();
      logic [15:0] exp, got;
      time ft;
      int len;
      cfg(0, 0, 3'b101, 0, 0, 0, 1);
      len = mkframe(9'h07F, 8, 0, 0, 1, exp);
      wr(2'd0, 9'h07F);
      tx_cap(len, 64, got, ft);
      chk(got[9:0] === exp[9:0], "R5 reserved size acts as 8", got[9:0], exp[9:0]);
      repeat (64) @(negedge clk);
   endtask

   task automatic t_rx_8n1();
      logic [15:0] f;
      int len;
      cfg(0, 0, 3'b011, 0, 0, 1, 0);
      len = mkframe(9'h0C6, 8, 0, 0, 1, f);
      rx_send(f, len, 64);
      repeat (20) @(negedge clk);
      chk(rx_ready === 1'b1, "R9 rx_ready after frame", rx_ready, 1);
      chk(rx_data === 9'h0C6, "R9 rx data 8N1", rx_data, 9'h0C6);
      chk(frame_err === 1'b0 && parity_err === 1'b0, "R9 clean frame no errors",
          {frame_err, parity_err}, 0);
      ack();
      chk(rx_ready === 1'b0, "R9 rd_ack clears ready", rx_ready, 0);
   endtask

   task automatic t_rx_parity_err();
      logic [15:0] f;
      int len;
      cfg(0, 0, 3'b011, 1, 0, 1, 0);
      len = mkframe(9'h035, 8, 1, 0, 1, f);
      f[9] = ~f[9];
      rx_send(f, len, 64);
      repeat (20) @(negedge clk);
      chk(parity_err === 1'b1, "R10 parity error flagged", parity_err, 1);
      chk(rx_data === 9'h035, "R10 data with bad parity", rx_data, 9'h035);
      ack();
      chk(parity_err === 1'b0, "R9 rd_ack clears parity_err", parity_err, 0);
   endtask

   task automatic t_rx_frame_err();
      logic [15:0] f;
      int len;
      cfg(0, 0, 3'b011, 0, 0, 1, 0);
      len = mkframe(9'h0E1, 8, 0, 0, 1, f);
      f[9] = 1'b0;
      rx_send(f, len, 64);
      repeat (20) @(negedge clk);
      chk(frame_err === 1'b1, "R11 frame error flagged", frame_err, 1);
      chk(rx_data === 9'h0E1, "R11 data with low stop", rx_data, 9'h0E1);
      ack();
      chk(frame_err === 1'b0, "R9 rd_ack clears frame_err", frame_err, 0);
      repeat (64) @(negedge clk);
   endtask

   task automatic t_rx_overrun();
      logic [15:0] f;
      int len;
      cfg(0, 0, 3'b011, 0, 0, 1, 0);
      len = mkframe(9'h03C, 8, 0, 0, 1, f);
      rx_send(f, len, 64);
      len = mkframe(9'h0C3, 8, 0, 0, 1, f);
      rx_send(f, len, 64);
      repeat (20) @(negedge clk);
      chk(overrun_err === 1'b1, "R12 overrun flagged", overrun_err, 1);
      chk(rx_data === 9'h03C, "R12 old word kept", rx_data, 9'h03C);
      ack();
      chk(overrun_err === 1'b0, "R9 rd_ack clears overrun", overrun_err, 0);
   endtask

   task automatic t_rx_glitch();
      logic [15:0] f;
      int len;
      cfg(0, 0, 3'b011, 0, 0, 1, 0);
      rxd = 1'b0;
      repeat (12) @(negedge clk);
      rxd = 1'b1;
      repeat (200) @(negedge clk);
      chk(rx_ready === 1'b0, "R8 short low pulse rejected", rx_ready, 0);
      len = mkframe(9'h05A, 8, 0, 0, 1, f);
      rx_send(f, len, 64);
      repeat (20) @(negedge clk);
      chk(rx_ready === 1'b1 && rx_data === 9'h05A, "R8 frame after rejected start",
          rx_data, 9'h05A);
      ack();
   endtask

   task automatic t_rx_dbl();
      logic [15:0] f;
      int len;
      cfg(0, 1, 3'b010, 0, 0, 1, 0);
      len = mkframe(9'h04B, 7, 0, 0, 1, f);
      rx_send(f, len, 32);
      repeat (20) @(negedge clk);
      chk(rx_ready === 1'b1 && rx_data === 9'h04B, "R2 R8 double-speed 7-bit receive",
          rx_data, 9'h04B);
      ack();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gpio();
      t_default_rate();
      t_tx_8n1();
      t_tx_back_to_back();
      t_tx_dbl_odd();
      t_tx_reserved();
      t_rx_8n1();
      t_rx_parity_err();
      t_rx_frame_err();
      t_rx_overrun();
      t_rx_glitch();
      t_rx_dbl();
      summary();
   end
endmodule